// File: doc/BRIEF.md
# Audio Serial Slave Transmitter

This block sends 16-bit audio samples on a serial data line. An external master drives both the bit clock and the word-select line, and the block only follows them. A host places each sample into a one-entry holding register. At the start of every channel slot the block copies the held sample into a shift register and sends it most significant bit first. Data changes on falling bit-clock edges. When a slot is longer than 16 bits, the remaining bits are sent as zeros. Slot boundaries come from the incoming word-select line, so slots of 16 or 32 bits per channel need no setting.

The host sets the framing with `cfg_fmt`: value 2'b01 selects MSB-justified framing, and any other value selects Philips framing. The host loads the first (left) sample and only then raises `cfg_en`. After that it answers the empty flag `txe`, or the interrupt `irq`, by writing the next sample. The `chside` flag follows word-select and tells the host which channel is in progress. If a slot starts with nothing new in the holding register, the block sends the previous sample again and sets a sticky underrun flag.

The block is controlled by a four-state machine:
- OFF: disabled, output held low.
- ARM: waiting for the first left slot.
- PEND: Philips one-bit lead-in before a load.
- SHIFT: sending bits.

Its transitions are:
- enable: OFF to ARM.
- left-start: ARM to SHIFT in MSB-justified framing, or ARM to PEND in Philips framing, on a word-select fall to low.
- first-fall: PEND to SHIFT, with a load.
- retrigger: SHIFT to SHIFT with a load, in MSB-justified framing, on a word-select change.
- lead-in: SHIFT to PEND, in Philips framing, on a word-select change.
- disable: any state to OFF.

Top module: `i2s_slave_tx`

## Requirements
- R1: After reset, `sd_out`, `irq`, `chside`, `udr` and `busy` are 0 and `txe` is 1.
- R2: A cycle with `wr_en` high stores `wr_data` in the holding register and clears `txe`. A write while the register is full replaces the old value. Writes are accepted while `cfg_en` is low.
- R3: Bit-clock and word-select are resynchronised through two flops. `sd_out` changes only on the third system clock after a falling bit-clock edge reaches the pins. Each sample is sent MSB first, and zeros follow its 16 bits until the next slot begins.
- R4: In Philips framing (`cfg_fmt` not 2'b01), the MSB of a slot goes out on the first falling bit-clock edge after the falling edge at which word-select changed.
- R5: In MSB-justified framing (`cfg_fmt` = 2'b01), the MSB goes out on the same falling edge at which word-select changed.
- R6: At each slot load, the holding register empties into the shifter and `txe` becomes 1, unless a write arrives in that same cycle.
- R7: `irq` is 1 exactly when `txe` is 1 and `txe_irq_en` is 1.
- R8: While enabled, `chside` equals the word-select level sampled at the latest rising bit-clock edge: 0 for left (word-select low), 1 for right.
- R9: After enable, nothing is sent until the first falling edge at which word-select has changed to low. Until then `sd_out` stays 0.
- R10: A slot load with an empty holding register sets `udr` and sends the last loaded sample again. `udr` stays 1 until a `udr_clr` pulse, and a new underrun in the same cycle as the pulse wins.
- R11: When `cfg_en` goes low, the block returns to OFF, `sd_out` and `chside` go to 0 on the next clock, and the holding register and its flag keep their values.
- R12: `busy` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block enable, raised after the first sample is written |
| cfg_fmt | input | 2 | Framing: 2'b01 MSB-justified, otherwise Philips |
| txe_irq_en | input | 1 | Enables the empty-buffer interrupt |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Sample to hold |
| udr_clr | input | 1 | Clears the underrun flag |
| sck_in | input | 1 | Bit clock from the master (asynchronous) |
| ws_in | input | 1 | Word select from the master (asynchronous) |
| sd_out | output | 1 | Serial data |
| txe | output | 1 | Holding register empty |
| irq | output | 1 | Interrupt request |
| chside | output | 1 | Channel side, 1 = right |
| udr | output | 1 | Sticky underrun flag |
| busy | output | 1 | Busy indication, tied low |

## Verification
A wrong state or a missed edge shows up within one bit period as a shifted or repeated serial word. The bench catches this when it rebuilds each slot from bits taken on rising bit-clock edges. A holding-register flag that is off by one load shows on `txe` and `irq` within a system clock of the slot start, and as an `udr` set at the wrong time. The bench's reference model follows the two-flop resynchronisation exactly, so it compares every output on every clock and sees a one-cycle timing slip at once.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    // Controller states of the slave transmitter
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // disabled, line held low
        ST_ARM   = 2'd1,   // waiting for first left slot
        ST_PEND  = 2'd2,   // one-bit lead-in (Philips)
        ST_SHIFT = 2'd3    // shifting sample bits
    } tx_state_e;

    // Framing code selecting MSB-justified alignment
    localparam logic [1:0] FMT_MSB_JUST = 2'b01;

endpackage

// File: rtl/i2s_tx_sync.sv
module i2s_tx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2s_tx_edge.sv
module i2s_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/i2s_tx_buf.sv
module i2s_tx_buf #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          load_i,
    input  logic          clr_udr_i,
    output logic [DW-1:0] word_o,
    output logic          empty_o,
    output logic          udr_o
);

    logic [DW-1:0] hold_q;
    logic [DW-1:0] last_q;
    logic          full_q;
    logic          udr_q;

    // Sample offered to the shifter: fresh one if present, else a repeat
    assign word_o  = full_q ? hold_q : last_q;
    assign empty_o = ~full_q;
    assign udr_o   = udr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            last_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (load_i) begin
                full_q <= 1'b0;
                if (full_q) begin
                    last_q <= hold_q;
                end
            end
            if (wr_i) begin
                hold_q <= wdata_i;
                full_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            udr_q <= 1'b0;
        end else if (load_i && !full_q) begin
            udr_q <= 1'b1;
        end else if (clr_udr_i) begin
            udr_q <= 1'b0;
        end
    end

    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !empty_o);

    a_r6_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !wr_i) |=> empty_o);

    a_r10_udr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && empty_o) |=> udr_o);

    a_r10_udr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (udr_o && !clr_udr_i) |=> udr_o);

endmodule

// File: rtl/i2s_tx_fsm.sv
module i2s_tx_fsm
    import i2s_tx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          msb_just_i,
    input  logic          sck_rise_i,
    input  logic          sck_fall_i,
    input  logic          ws_i,
    input  logic [DW-1:0] word_i,
    output logic          load_o,
    output logic          sd_o,
    output logic          chside_o
);

    tx_state_e     state_q, state_d;
    logic          ws_last_q;
    logic [DW-1:0] shreg_q;
    logic          sd_q;
    logic          chside_q;
    logic          ws_change;
    logic          load_c;
    logic          shift_c;

    assign ws_change = sck_fall_i && (ws_i != ws_last_q);

    // Next-state and datapath-control decode
    always_comb begin
        state_d = state_q;
        load_c  = 1'b0;
        shift_c = 1'b0;
        if (!en_i) begin
            state_d = ST_OFF;                       // disable
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_ARM;           // enable
                ST_ARM: begin
                    if (ws_change && !ws_i) begin   // left-start
                        if (msb_just_i) begin
                            load_c  = 1'b1;
                            state_d = ST_SHIFT;
                        end else begin
                            state_d = ST_PEND;
                        end
                    end
                end
                ST_PEND: begin
                    if (sck_fall_i) begin           // first-fall
                        load_c  = 1'b1;
                        state_d = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (ws_change) begin
                        if (msb_just_i) begin       // retrigger
                            load_c = 1'b1;
                        end else begin              // lead-in
                            shift_c = 1'b1;
                            state_d = ST_PEND;
                        end
                    end else if (sck_fall_i) begin
                        shift_c = 1'b1;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q      <= 1'b0;
            shreg_q   <= '0;
            chside_q  <= 1'b0;
            ws_last_q <= 1'b0;
        end else begin
            if (state_q == ST_OFF || sck_fall_i) begin
                ws_last_q <= ws_i;
            end
            if (!en_i) begin
                sd_q     <= 1'b0;
                shreg_q  <= '0;
                chside_q <= 1'b0;
            end else begin
                if (load_c) begin
                    {sd_q, shreg_q} <= {word_i, 1'b0};
                end else if (shift_c) begin
                    {sd_q, shreg_q} <= {shreg_q, 1'b0};
                end
                if (sck_rise_i) begin
                    chside_q <= ws_i;
                end
            end
        end
    end

    assign load_o   = load_c;
    assign sd_o     = sd_q;
    assign chside_o = chside_q;

    a_r11_sd_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!sd_o && !chside_o));

    a_r3_sd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !sck_fall_i) |=> $stable(sd_q));

    a_r8_chside_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !sck_rise_i) |=> $stable(chside_q));

    a_r9_arm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |-> !sd_q);

endmodule

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx
    import i2s_tx_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_fmt,
    input  logic              txe_irq_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              udr_clr,
    input  logic              sck_in,
    input  logic              ws_in,
    output logic              sd_out,
    output logic              txe,
    output logic              irq,
    output logic              chside,
    output logic              udr,
    output logic              busy
);

    localparam int PINS = 2;

    logic [PINS-1:0]   pins_s;
    logic              sck_s;
    logic              ws_s;
    logic              sck_rise;
    logic              sck_fall;
    logic              load;
    logic [DATA_W-1:0] load_word;
    logic              empty;

    i2s_tx_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ws_in, sck_in}),
        .sync_o  (pins_s)
    );

    assign sck_s = pins_s[0];
    assign ws_s  = pins_s[1];

    i2s_tx_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sck_s),
        .rise_o  (sck_rise),
        .fall_o  (sck_fall)
    );

    i2s_tx_buf #(.DW(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_en),
        .wdata_i   (wr_data),
        .load_i    (load),
        .clr_udr_i (udr_clr),
        .word_o    (load_word),
        .empty_o   (empty),
        .udr_o     (udr)
    );

    i2s_tx_fsm #(.DW(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cfg_en),
        .msb_just_i (cfg_fmt == FMT_MSB_JUST),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .ws_i       (ws_s),
        .word_i     (load_word),
        .load_o     (load),
        .sd_o       (sd_out),
        .chside_o   (chside)
    );

    assign txe  = empty;
    assign irq  = empty & txe_irq_en;
    assign busy = 1'b0;

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !txe_irq_en |-> !irq);

endmodule

// File: tb/i2s_slave_tx_tb_top.sv
`timescale 1ns/1ps
module i2s_slave_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 8;
    localparam int MAX_SLOTS  = 16;
    localparam int SLOT_MAX   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_fmt = 2'b00;
    logic        txe_irq_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        udr_clr = 1'b0;
    logic        sck_in = 1'b1;
    logic        ws_in = 1'b1;
    logic        sd_out, txe, irq, chside, udr, busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_slave_tx dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_fmt(cfg_fmt),
        .txe_irq_en(txe_irq_en), .wr_en(wr_en), .wr_data(wr_data),
        .udr_clr(udr_clr), .sck_in(sck_in), .ws_in(ws_in),
        .sd_out(sd_out), .txe(txe), .irq(irq), .chside(chside),
        .udr(udr), .busy(busy)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit run_cmp = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_st;          // 0 off, 1 armed, 2 lead-in, 3 sending
    bit [3:0]    h_sck, h_ws;   // input history, bit 0 newest
    bit [15:0]   m_buf, m_last, m_sh;
    bit          m_full, m_udr, m_sd, m_chs, m_wsl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; h_sck = 0; h_ws = 0; m_buf = 0; m_last = 0; m_sh = 0;
            m_full = 0; m_udr = 0; m_sd = 0; m_chs = 0; m_wsl = 0;
        end else begin
            bit fall, rise, w, msb, chg, ld, sh, old_full;
            bit [15:0] word;
            int nst;
            h_sck = {h_sck[2:0], sck_in};
            h_ws  = {h_ws[2:0], ws_in};
            fall = h_sck[3] && !h_sck[2];
            rise = !h_sck[3] && h_sck[2];
            w    = h_ws[2];
            msb  = (cfg_fmt == 2'b01);
            chg  = fall && (w != m_wsl);
            ld = 0; sh = 0; nst = m_st;
            if (m_st == 0 || fall) m_wsl = w;
            if (!cfg_en) nst = 0;
            else if (m_st == 0) nst = 1;
            else if (m_st == 1) begin
                if (chg && !w) begin
                    if (msb) begin ld = 1; nst = 3; end else nst = 2;
                end
            end else if (m_st == 2) begin
                if (fall) begin ld = 1; nst = 3; end
            end else begin
                if (chg) begin
                    if (msb) ld = 1; else begin sh = 1; nst = 2; end
                end else if (fall) sh = 1;
            end
            m_st = nst;
            word = m_full ? m_buf : m_last;
            if (!cfg_en) begin
                m_sd = 0; m_sh = 0; m_chs = 0;
            end else begin
                if (ld) begin m_sd = word[15]; m_sh = {word[14:0], 1'b0}; end
                else if (sh) begin m_sd = m_sh[15]; m_sh = {m_sh[14:0], 1'b0}; end
                if (rise) m_chs = w;
            end
            old_full = m_full;
            if (ld) begin
                if (old_full) m_last = m_buf;
                m_full = 0;
            end
            if (ld && !old_full) m_udr = 1;
            else if (udr_clr) m_udr = 0;
            if (wr_en) begin m_buf = wr_data; m_full = 1; end
        end
    end

    // Compare every cycle, one time unit after the falling clock edge
    always begin
        @(negedge clk);
        #1;
        if (run_cmp) begin
            check("R3 sd_out", sd_out, m_sd);
            check("R6 txe", txe, !m_full);
            check("R7 irq", irq, txe_irq_en & !m_full);
            check("R8 chside", chside, m_chs);
            check("R10 udr", udr, m_udr);
            check("R12 busy", busy, 1'b0);
        end
    end

    // ---------------- host ----------------
    bit          host_on = 0;
    logic [15:0] host_q[$];
    logic [15:0] force_q[$];

    always @(negedge clk) begin
        if (wr_en) begin
            wr_en = 1'b0;
        end else if (force_q.size() > 0) begin
            wr_data = force_q.pop_front();
            wr_en   = 1'b1;
        end else if (host_on && txe && host_q.size() > 0) begin
            wr_data = host_q.pop_front();
            wr_en   = 1'b1;
        end
    end

    // ---------------- master ----------------
    bit rx [MAX_SLOTS][SLOT_MAX];

    task automatic bitclk(input bit wsv, input bit chg, output bit cap);
        @(negedge clk);
        sck_in = 1'b0;
        if (chg) ws_in = wsv;
        repeat (HALF_BIT - 1) @(negedge clk);
        @(negedge clk);
        sck_in = 1'b1;
        cap = sd_out;
        repeat (HALF_BIT - 1) @(negedge clk);
    endtask

    task automatic run_frames(input int nslots, input int slen);
        for (int s = 0; s < nslots; s++) begin
            for (int b = 0; b < slen; b++) begin
                bit c;
                bitclk(bit'(s % 2), b == 0, c);
                rx[s][b] = c;
            end
        end
    endtask

    function automatic logic [15:0] rx_word(input int s, input int slen, input bit philips);
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin
            int idx;
            idx = s * slen + i + int'(philips);
            v[15 - i] = rx[idx / slen][idx % slen];
        end
        return v;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all R) actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- scenario ----------------
    logic [15:0] exp_a [5];

    initial begin
        exp_a[0] = 16'h1234; exp_a[1] = 16'h5678; exp_a[2] = 16'h9ABC;
        exp_a[3] = 16'hDEF0; exp_a[4] = 16'h0F0F;

        repeat (4) @(negedge clk);
        #1;
        check("R1 sd_out reset", sd_out, 1'b0);
        check("R1 txe reset", txe, 1'b1);
        check("R1 irq reset", irq, 1'b0);
        check("R1 chside reset", chside, 1'b0);
        check("R1 udr reset", udr, 1'b0);
        check("R1 busy reset", busy, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        run_cmp = 1;

        // Philips framing, 32-bit slots; prefill with overwrite while disabled
        cfg_fmt = 2'b00;
        txe_irq_en = 1'b1;
        force_q.push_back(16'hAAAA);
        force_q.push_back(16'h1234);
        repeat (6) @(negedge clk);
        #1;
        check("R2 txe after prefill", txe, 1'b0);
        check("R7 irq while full", irq, 1'b0);
        host_q = '{16'h5678, 16'h9ABC, 16'hDEF0, 16'h0F0F, 16'h8001, 16'h7FFE};
        host_on = 1;
        @(negedge clk);
        cfg_en = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            bit c;
            bitclk(1'b1, 1'b0, c);
            check("R9 quiet before left start", c, 1'b0);
        end
        run_frames(6, 32);
        for (int s = 0; s < 5; s++) begin
            check($sformatf("R4 philips word slot %0d (R2 overwrite on slot 0)", s),
                  rx_word(s, 32, 1'b1), exp_a[s]);
        end
        for (int s = 0; s < 5; s++) begin
            logic [14:0] pad;
            for (int b = 17; b < 32; b++) pad[b - 17] = rx[s][b];
            check($sformatf("R3 zero padding slot %0d", s), pad, 15'h0);
        end
        check("R10 no underrun when fed", udr, 1'b0);

        // Disable mid-stream
        @(negedge clk);
        cfg_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R11 sd_out low when off", sd_out, 1'b0);
        check("R11 chside low when off", chside, 1'b0);
        check("R11 buffer retained", txe, 1'b0);

        // MSB-justified framing, 16-bit slots, underrun
        host_on = 0;
        txe_irq_en = 1'b0;
        cfg_fmt = 2'b01;
        force_q.push_back(16'hC3A5);
        repeat (4) @(negedge clk);
        cfg_en = 1'b1;
        repeat (3) @(negedge clk);
        run_frames(4, 16);
        check("R5 msb-justified word slot 0", rx_word(0, 16, 1'b0), 16'hC3A5);
        for (int s = 1; s < 4; s++) begin
            check($sformatf("R10 repeated word slot %0d", s), rx_word(s, 16, 1'b0), 16'hC3A5);
        end
        repeat (4) @(negedge clk);
        #1;
        check("R10 underrun flagged", udr, 1'b1);
        check("R6 txe after load", txe, 1'b1);
        check("R7 irq masked", irq, 1'b0);
        check("R8 chside right", chside, 1'b1);
        @(negedge clk);
        txe_irq_en = 1'b1;
        #1;
        check("R7 irq raised", irq, 1'b1);
        @(negedge clk);
        udr_clr = 1'b1;
        @(negedge clk);
        udr_clr = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R10 underrun cleared", udr, 1'b0);
        check("R12 busy low", busy, 1'b0);

        @(negedge clk);
        cfg_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R11 off at end", sd_out, 1'b0);
        run_cmp = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule